// File: doc/BRIEF.md
# Multi-channel input capture timer

This block timestamps signal edges. Three input pins feed three capture channels that all share one free-running up counter. The counter advances once per tick of a prescaler, and the prescaler divisor is picked from a fixed table of eight values. When an enabled channel sees an edge of the kind it is set to watch, it copies the counter into its own hold register. It also records the pin level at that moment and raises its capture flag.

Software drives the unit through a small word-addressed register bus with single-cycle writes and combinational reads. A single interrupt line reports any flagged channel whose interrupt enable is set. To measure a pulse width, set a channel to capture on both edges and take the difference of successive hold values. The level bit tells a rising capture from a falling one.

Top module: `capture_timer`

## Requirements
- R1: After reset, every readable register returns 0, the counter is stopped and `irq` is low.
- R2: Control word (address 0) layout: bit 0 is the run bit, bits 3:1 select the divisor, bits 6:4 enable channels 0..2, bits 9:7 enable their interrupts, and bits 15:10 hold a 2-bit edge mode per channel (channel i at bits 11+2i:10+2i). While run is set, the counter (read at address 2) advances by one every N clock cycles. N is 1, 4, 16, 32, 64, 96, 112 or 128 for select codes 0 to 7. While run is clear, the counter and the prescaler phase hold still.
- R3: The counter is CNT_W bits wide (24 by default). After all ones it wraps to zero on the next tick.
- R4: Each pin passes through two synchronizer flops. Edges are judged on prescaler ticks against the level seen at the previous tick. Mode 00 captures rising edges, 01 falling edges, and 10 or 11 both. On a capture, the channel's hold register (address 4+i) takes the counter value from before that tick's increment.
- R5: A channel whose enable bit is clear ignores its pin: its hold value, level, flag and overrun bits do not change.
- R6: The status word (address 1) bits 5:3 give, for channels 0..2, the synchronized pin level at that channel's most recent capture.
- R7: Status bits 2:0 are the capture flags. A capture sets the flag. Writing 1 to the flag's bit at address 1 clears it. A capture in the same cycle as a clear leaves the flag set.
- R8: Status bits 8:6 are sticky overrun bits. One is set when a capture hits a channel whose flag is already set, and the hold register is overwritten. Writing 1 to the bit clears it, with the same priority rule as R7.
- R9: `irq` is high exactly when some channel has both its flag and its interrupt enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin | input | NUM_CH | Asynchronous capture inputs, one per channel |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Word address for reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong prescaler phase or counter value shows at the count address within one divisor period. From then on it shows in every hold value captured. A wrong previous-level register produces a missing or extra capture. Three cycles after the pin moves, that appears as a wrong flag, level or hold value, and `irq` follows in the same cycle. Flag and overrun priority faults are exposed by clear writes that land on the capture cycle itself. All of these are compared against a cycle-by-cycle model driven by random pin, control and clear traffic.

// File: rtl/ct_pkg.sv
package ct_pkg;

    localparam int SEL_W = 3;
    localparam int PRE_W = 8;

    localparam int ADR_CTRL  = 0;
    localparam int ADR_STAT  = 1;
    localparam int ADR_CNT   = 2;
    localparam int ADR_HOLD0 = 4;

    typedef enum logic [1:0] {
        EDGE_RISE  = 2'b00,
        EDGE_FALL  = 2'b01,
        EDGE_ANY   = 2'b10,
        EDGE_ANY_B = 2'b11
    } edge_mode_e;

    // divisor table, deliberately not all powers of two
    function automatic logic [PRE_W-1:0] ct_divisor(input logic [SEL_W-1:0] sel);
        case (sel)
            3'd0:    ct_divisor = 8'd1;
            3'd1:    ct_divisor = 8'd4;
            3'd2:    ct_divisor = 8'd16;
            3'd3:    ct_divisor = 8'd32;
            3'd4:    ct_divisor = 8'd64;
            3'd5:    ct_divisor = 8'd96;
            3'd6:    ct_divisor = 8'd112;
            default: ct_divisor = 8'd128;
        endcase
    endfunction

endpackage

// File: rtl/ct_prescaler.sv
module ct_prescaler
    import ct_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    typedef struct packed {
        logic [PRE_W-1:0] phase;
    } pre_state_t;

    pre_state_t       st_d, st_q;
    logic [PRE_W-1:0] limit;

    always_comb begin
        st_d  = st_q;
        limit = ct_divisor(sel) - PRE_W'(1);
        // ">=" keeps a shrinking divisor from running the phase all the way round
        tick  = run && (st_q.phase >= limit);
        if (!run || tick) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ct_counter.sv
module ct_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CNT_W-1:0] value
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            // natural wrap from all ones back to zero
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        value = st_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ct_channel.sv
module ct_channel
    import ct_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin,
    input  logic             run,
    input  logic             tick,
    input  logic             en,
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] cnt,
    input  logic             clr_flag,
    input  logic             clr_ovr,
    output logic             cap,
    output logic             flag,
    output logic             level,
    output logic             ovr,
    output logic [CNT_W-1:0] hold
);

    typedef struct packed {
        logic             sync1;
        logic             sync2;
        logic             prev;
        logic             flag;
        logic             level;
        logic             ovr;
        logic [CNT_W-1:0] hold;
    } ch_state_t;

    ch_state_t  st_d, st_q;
    edge_mode_e mode_e;
    logic       rise, fall, hit;

    always_comb begin
        st_d   = st_q;
        mode_e = edge_mode_e'(mode);

        rise = st_q.sync2 && !st_q.prev;
        fall = !st_q.sync2 && st_q.prev;
        case (mode_e)
            EDGE_RISE: hit = rise;
            EDGE_FALL: hit = fall;
            default:   hit = rise || fall;
        endcase

        cap = tick && en && hit;

        st_d.sync1 = pin;
        st_d.sync2 = st_q.sync1;
        // follow the pin while idle so that starting the counter gives no stale edge
        if (tick || !run) begin
            st_d.prev = st_q.sync2;
        end

        if (cap) begin
            st_d.hold  = cnt;
            st_d.level = st_q.sync2;
        end

        // a capture wins over a clear in the same cycle
        st_d.flag = cap || (st_q.flag && !clr_flag);
        st_d.ovr  = (cap && st_q.flag) || (st_q.ovr && !clr_ovr);

        flag  = st_q.flag;
        level = st_q.level;
        ovr   = st_q.ovr;
        hold  = st_q.hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/capture_timer.sv
module capture_timer
    import ct_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 24,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] cap_pin,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    localparam int SEL_LSB  = 1;
    localparam int EN_LSB   = SEL_LSB + SEL_W;
    localparam int IE_LSB   = EN_LSB + NUM_CH;
    localparam int MD_LSB   = IE_LSB + NUM_CH;
    localparam int LVL_LSB  = NUM_CH;
    localparam int OVR_LSB  = 2 * NUM_CH;
    localparam int STAT_W   = 3 * NUM_CH;
    localparam int HOLD_TOT = NUM_CH * CNT_W;

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADR_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADR_STAT);
    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(ADR_CNT);

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
    } top_state_t;

    top_state_t st_d, st_q;

    logic                run;
    logic [SEL_W-1:0]    sel;
    logic [NUM_CH-1:0]   en_vec, ie_vec;
    logic                tick;
    logic [CNT_W-1:0]    cnt_val;
    logic [NUM_CH-1:0]   cap_vec, flag_vec, lvl_vec, ovr_vec;
    logic [NUM_CH-1:0]   clr_flag_vec, clr_ovr_vec;
    logic [HOLD_TOT-1:0] hold_flat;
    logic                stat_wr;

    // control register, next state
    always_comb begin
        st_d = st_q;
        if (bus_wr && bus_addr == A_CTRL) begin
            st_d.ctrl = bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run     = st_q.ctrl[0];
    assign sel     = st_q.ctrl[SEL_LSB +: SEL_W];
    assign en_vec  = st_q.ctrl[EN_LSB +: NUM_CH];
    assign ie_vec  = st_q.ctrl[IE_LSB +: NUM_CH];
    assign stat_wr = bus_wr && (bus_addr == A_STAT);

    ct_prescaler u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .sel   (sel),
        .tick  (tick)
    );

    ct_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .value (cnt_val)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign clr_flag_vec[i] = stat_wr && bus_wdata[i];
        assign clr_ovr_vec[i]  = stat_wr && bus_wdata[OVR_LSB + i];

        ct_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (cap_pin[i]),
            .run      (run),
            .tick     (tick),
            .en       (en_vec[i]),
            .mode     (st_q.ctrl[MD_LSB + 2*i +: 2]),
            .cnt      (cnt_val),
            .clr_flag (clr_flag_vec[i]),
            .clr_ovr  (clr_ovr_vec[i]),
            .cap      (cap_vec[i]),
            .flag     (flag_vec[i]),
            .level    (lvl_vec[i]),
            .ovr      (ovr_vec[i]),
            .hold     (hold_flat[i*CNT_W +: CNT_W])
        );
    end

    // read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL) begin
            bus_rdata = st_q.ctrl;
        end else if (bus_addr == A_STAT) begin
            bus_rdata[STAT_W-1:0] = {ovr_vec, lvl_vec, flag_vec};
        end else if (bus_addr == A_CNT) begin
            bus_rdata[CNT_W-1:0] = cnt_val;
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (bus_addr == ADDR_W'(ADR_HOLD0 + i)) begin
                    bus_rdata[CNT_W-1:0] = hold_flat[i*CNT_W +: CNT_W];
                end
            end
        end
    end

    assign irq = |(flag_vec & ie_vec);

endmodule

// File: rtl/ct_checker.sv
module ct_checker #(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 24
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    run,
    input logic                    tick,
    input logic                    bus_wr,
    input logic [CNT_W-1:0]        cnt,
    input logic [NUM_CH-1:0]       en,
    input logic [NUM_CH-1:0]       ie,
    input logic [NUM_CH-1:0]       cap,
    input logic [NUM_CH-1:0]       flag,
    input logic [NUM_CH-1:0]       ovr,
    input logic [NUM_CH*CNT_W-1:0] hold,
    input logic                    irq
);

    AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n) tick |-> run); // R2
    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !tick |=> $stable(cnt)); // R2
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (tick && (&cnt)) |=> (cnt == '0)); // R3

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) !en[i] |=> $stable(hold[i*CNT_W +: CNT_W])); // R5
        AST_CAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) cap[i] |=> flag[i]); // R7
        AST_OVR_ON_REHIT: assert property (@(posedge clk) disable iff (!rst_n) (cap[i] && flag[i]) |=> ovr[i]); // R8
        AST_IRQ_ON_CAP: assert property (@(posedge clk) disable iff (!rst_n) (cap[i] && ie[i] && !bus_wr) |=> irq); // R9
    end

endmodule

bind capture_timer ct_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .tick   (tick),
    .bus_wr (bus_wr),
    .cnt    (cnt_val),
    .en     (en_vec),
    .ie     (ie_vec),
    .cap    (cap_vec),
    .flag   (flag_vec),
    .ovr    (ovr_vec),
    .hold   (hold_flat),
    .irq    (irq)
);

// File: tb/capture_timer_tb_top.sv
`timescale 1ns/1ps
module capture_timer_tb_top;

    localparam int NCH = 3;
    localparam int CW  = 12;   // narrow counter so wrap is reachable
    localparam int DW  = 32;
    localparam int AW  = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;      // 125 MHz

    logic           rst_n;
    logic [NCH-1:0] pins;
    logic           bus_wr;
    logic [AW-1:0]  bus_addr;
    logic [DW-1:0]  bus_wdata;
    wire  [DW-1:0]  bus_rdata;
    wire            irq;

    int n_chk  = 0;
    int n_fail = 0;

    capture_timer #(.NUM_CH(NCH), .CNT_W(CW), .DATA_W(DW), .ADDR_W(AW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_pin   (pins),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // ---------------- reference model built from the requirements ----------------
    logic [DW-1:0]  m_ctrl;
    int             m_pre;
    logic [CW-1:0]  m_cnt;
    logic [NCH-1:0] m_s1, m_s2, m_prev, m_flag, m_lvl, m_ovr;
    logic [CW-1:0]  m_hold [NCH];

    function automatic int div_of(input logic [2:0] s);
        int t [8] = '{1, 4, 16, 32, 64, 96, 112, 128};
        return t[s];
    endfunction

    always @(posedge clk or negedge rst_n) begin : model
        logic           run_v, tick_v, hit_v;
        logic [1:0]     md_v;
        logic [NCH-1:0] cap_v, clrf_v, clro_v;
        if (!rst_n) begin
            m_ctrl <= '0; m_pre <= 0; m_cnt <= '0;
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0;
            m_flag <= '0; m_lvl <= '0; m_ovr <= '0;
            for (int i = 0; i < NCH; i++) m_hold[i] <= '0;
        end else begin
            run_v  = m_ctrl[0];
            tick_v = run_v && (m_pre >= div_of(m_ctrl[3:1]) - 1);
            m_pre <= (!run_v || tick_v) ? 0 : m_pre + 1;
            if (tick_v) m_cnt <= m_cnt + 1'b1;
            clrf_v = (bus_wr && bus_addr == 1) ? bus_wdata[2:0] : 3'b000;
            clro_v = (bus_wr && bus_addr == 1) ? bus_wdata[8:6] : 3'b000;
            for (int i = 0; i < NCH; i++) begin
                md_v = m_ctrl[10 + 2*i +: 2];
                if (md_v == 2'b00)      hit_v = m_s2[i] && !m_prev[i];
                else if (md_v == 2'b01) hit_v = !m_s2[i] && m_prev[i];
                else                    hit_v = m_s2[i] != m_prev[i];
                cap_v[i] = tick_v && m_ctrl[4 + i] && hit_v;
                if (cap_v[i]) begin
                    m_hold[i] <= m_cnt;
                    m_lvl[i]  <= m_s2[i];
                end
                m_flag[i] <= cap_v[i] || (m_flag[i] && !clrf_v[i]);
                m_ovr[i]  <= (cap_v[i] && m_flag[i]) || (m_ovr[i] && !clro_v[i]);
                if (tick_v || !run_v) m_prev[i] <= m_s2[i];
            end
            m_s1 <= pins;
            m_s2 <= m_s1;
            if (bus_wr && bus_addr == 0) m_ctrl <= bus_wdata;
        end
    end

    function automatic logic [DW-1:0] exp_read(input int a);
        logic [DW-1:0] r = '0;
        case (a)
            0: r = m_ctrl;
            1: r[8:0] = {m_ovr, m_lvl, m_flag};
            2: r[CW-1:0] = m_cnt;
            4, 5, 6: r[CW-1:0] = m_hold[a-4];
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic [DW-1:0] mk_ctrl(input logic run, input logic [2:0] sel,
                                              input logic [2:0] en, input logic [2:0] ie,
                                              input logic [1:0] m0, input logic [1:0] m1,
                                              input logic [1:0] m2);
        return {16'h0, m2, m1, m0, ie, en, sel, run};
    endfunction

    // ---------------- checking helpers ----------------
    task automatic check(input string tag, input string what, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        string t;
        @(negedge clk);
        for (int a = 0; a < 8; a++) begin
            bus_addr = AW'(a);
            #0.2;
            if (tag != "") t = tag;
            else if (a == 1) t = "R7";
            else if (a >= 4) t = "R4";
            else t = "R2";
            check(t, $sformatf("read addr %0d", a), bus_rdata, exp_read(a));
        end
        check((tag != "") ? tag : "R9", "irq", {31'b0, irq},
              {31'b0, |(m_flag & m_ctrl[9:7])});
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic set_pin(input int i, input logic v);
        @(negedge clk);
        pins[i] = v;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [DW-1:0] st;
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; pins = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        wait_cyc(4);
        rst_n = 1'b1;

        // R1: reset state
        check_all("R1");

        // R2: every divisor, then counter frozen while stopped
        for (int s = 0; s < 8; s++) begin
            wr(0, mk_ctrl(1'b1, 3'(s), 3'b000, 3'b000, 2'b00, 2'b00, 2'b00));
            wait_cyc(300);
            check_all("R2");
        end
        wr(0, '0);
        wait_cyc(50);
        check_all("R2");

        // R3: wrap of the narrow counter
        wr(0, mk_ctrl(1'b1, 3'd0, 3'b000, 3'b000, 2'b00, 2'b00, 2'b00));
        wait_cyc(4200);
        check_all("R3");

        // R4: ch0 rising, ch1 falling, ch2 both
        wr(0, mk_ctrl(1'b1, 3'd0, 3'b111, 3'b000, 2'b00, 2'b01, 2'b10));
        set_pin(0, 1'b1); wait_cyc(6); check_all("R4");
        set_pin(0, 1'b0); wait_cyc(6); check_all("R4");   // falling ignored in rise mode
        set_pin(1, 1'b1); wait_cyc(6); check_all("R4");   // rising ignored in fall mode
        set_pin(1, 1'b0); wait_cyc(6); check_all("R4");

        // R6: both-edge channel records the level
        set_pin(2, 1'b1); wait_cyc(6); check_all("R6");
        @(negedge clk); bus_addr = AW'(1); #0.2;
        check("R6", "level ch2 high", {31'b0, bus_rdata[5]}, 32'd1);
        set_pin(2, 1'b0); wait_cyc(6); check_all("R6");
        @(negedge clk); bus_addr = AW'(1); #0.2;
        check("R6", "level ch2 low", {31'b0, bus_rdata[5]}, 32'd0);

        // R8: ch0 flag still set, new capture -> overrun
        set_pin(0, 1'b1); wait_cyc(6); check_all("R8");
        @(negedge clk); bus_addr = AW'(1); #0.2;
        check("R8", "overrun ch0", {31'b0, bus_rdata[6]}, 32'd1);
        wr(1, 32'h0000_01C0); wait_cyc(2); check_all("R8");

        // R7: clear flags, then clear landing on the capture cycle
        wr(1, 32'h0000_0007); wait_cyc(2); check_all("R7");
        wr(0, mk_ctrl(1'b1, 3'd0, 3'b111, 3'b000, 2'b10, 2'b01, 2'b10));
        @(negedge clk); pins[0] = ~pins[0];
        @(negedge clk);
        @(negedge clk); bus_wr = 1'b1; bus_addr = AW'(1); bus_wdata = 32'h0000_0001;
        @(negedge clk); bus_wr = 1'b0; bus_addr = AW'(1); #0.2;
        check("R7", "flag kept on capture+clear", {31'b0, bus_rdata[0]}, 32'd1);
        check_all("R7");

        // R9: interrupt enables
        wr(0, mk_ctrl(1'b1, 3'd0, 3'b111, 3'b001, 2'b10, 2'b10, 2'b10));
        check_all("R9");
        wr(1, 32'h0000_0001); wait_cyc(1); check_all("R9");
        set_pin(1, 1'b1); wait_cyc(6); check_all("R9");     // flag without enable
        wr(0, mk_ctrl(1'b1, 3'd0, 3'b111, 3'b010, 2'b10, 2'b10, 2'b10));
        check_all("R9");

        // R5: only ch1 enabled; ch0 and ch2 toggle
        wr(1, 32'h0000_01FF);
        wr(0, mk_ctrl(1'b1, 3'd1, 3'b010, 3'b111, 2'b10, 2'b10, 2'b10));
        set_pin(0, ~pins[0]); set_pin(2, ~pins[2]); wait_cyc(20);
        check_all("R5");
        set_pin(0, ~pins[0]); set_pin(2, ~pins[2]); wait_cyc(20);
        check_all("R5");

        // random traffic
        for (int it = 0; it < 600; it++) begin
            @(negedge clk);
            for (int i = 0; i < NCH; i++)
                if ($urandom % 5 == 0) pins[i] = ~pins[i];
            if (it % 60 == 0) begin
                st = $urandom;
                wr(0, mk_ctrl(($urandom % 8) != 0, 3'($urandom % 3), st[2:0], st[5:3],
                              st[7:6], st[9:8], st[11:10]));
            end else if ($urandom % 9 == 0) begin
                wr(1, $urandom);
            end
            if (it % 15 == 0) check_all("");
        end
        check_all("");

        finish_run();
    end

endmodule